// File: doc/BRIEF.md
# Dual-Mode Command and Data Byte FIFO

This block is the byte-wide FIFO port of a SCSI host adapter, as seen from the CPU. A write to the FIFO goes to one of two places. While the adapter is collecting a command, the byte is appended to a command buffer. At all other times it is pushed into a transfer buffer. A read pops the oldest byte from the transfer buffer. The block keeps a signed phase byte count: pushes raise it, pops lower it, and loading a status response sets it directly. It also presents a flags byte that carries the FIFO occupancy, plus an interrupt line with an interrupt code.

Three commands act on the block: flush, load status response, and soft reset. Each arrives as a single-cycle strobe. Command collection is started and ended by separate strobes from the adapter's command sequencer. Only one access is served in a cycle. A command strobe takes precedence over a write, and a write takes precedence over a read. The transfer pointers return to zero every time the buffer drains. A write is refused one entry before the storage is physically full, so at most DEPTH-1 bytes are held.

Top module: `scsi_byte_fifo`

## Requirements
- R1: After the asynchronous reset, rd_data, phase_count, flags, overrun, irq, intr_code and cmd_len are all zero, and command collection is off.
- R2: While collection is on, each write stores its byte at command index cmd_len and increments cmd_len. The transfer buffer, phase_count and flags are unchanged. cmd_rd_data returns the byte stored at cmd_rd_idx. A collect_start strobe turns collection on and sets cmd_len to 0. A collect_end strobe turns collection off.
- R3: A write during collection with cmd_len equal to CMD_DEPTH is dropped. cmd_len stays unchanged, and overrun is high for the one cycle after that write.
- R4: Outside collection, a write stores the byte, and both phase_count and the flags occupancy go up by one. If the write pointer is at DEPTH-1 (DEPTH-1 bytes pushed since the last drain), the write is dropped, nothing changes, and overrun pulses for one cycle.
- R5: A read while phase_in is 3'b000 sets rd_data to 0 and does not pop: flags and phase_count are unchanged.
- R6: A read with phase_in nonzero and the buffer not empty returns the oldest byte on rd_data in the cycle after the read, and decrements phase_count and the flags occupancy.
- R7: A read with phase_in nonzero and the buffer empty leaves rd_data, phase_count and flags unchanged.
- R8: When a pop empties the buffer, both pointers return to zero, so DEPTH-1 further writes are accepted before an overrun.
- R9: A status-response command (cmd_op 2'b01) loads the buffer with status_byte followed by 8'h00, sets phase_count to 2 and the flags occupancy to 2, raises irq, and sets intr_code to 8'h08.
- R10: A flush command (cmd_op 2'b00) sets intr_code to 8'h08 and flags to 0, and leaves phase_count and irq unchanged.
- R11: A soft-reset command (cmd_op 2'b10) returns every output and the collection mode to the R1 state.
- R12: irq_ack clears irq and intr_code in the next cycle, unless a flush or status command arrives in the same cycle.
- R13: flags bits 4:0 hold the occupancy (bytes pushed minus bytes popped since the last drain, flush or load), and bits 7:5 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe to the FIFO |
| wr_data | input | 8 | Byte written |
| rd_en | input | 1 | CPU read strobe from the FIFO |
| phase_in | input | 3 | Bus phase bits; 3'b000 marks data-out |
| rd_data | output | 8 | Last byte read (registered) |
| collect_start | input | 1 | Turn command collection on and clear cmd_len |
| collect_end | input | 1 | Turn command collection off |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 flush, 01 status response, 10 soft reset, 11 none |
| status_byte | input | 8 | Status byte loaded by the status command |
| irq_ack | input | 1 | Interrupt acknowledge |
| cmd_rd_idx | input | CIW | Command buffer read index |
| cmd_rd_data | output | 8 | Command buffer byte at cmd_rd_idx |
| cmd_len | output | CLW | Command bytes collected |
| phase_count | output | CNT_W | Signed phase byte count, two's complement |
| flags | output | 8 | Occupancy in bits 4:0 |
| overrun | output | 1 | One-cycle pulse after a dropped write |
| irq | output | 1 | Interrupt request |
| intr_code | output | 8 | Interrupt cause, 8'h08 = function complete |

## Verification
Directed sequences cover the boundaries. Filling up to DEPTH-1 checks that the early refusal happens exactly there. Draining and refilling shows that the pointers collapse, because a stale pointer would cause an early overrun. A read in the data-out phase, a read from an empty buffer, and a seventeenth command byte each check a case where nothing is popped or stored. A status load followed by two reads shows the byte order. Seeded random mixes of writes, reads, phase values, flushes, status loads and acknowledges then exercise the priorities and the signed count against a bench model built from the requirements.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [1:0] {
    OP_FLUSH   = 2'd0,
    OP_STATUS  = 2'd1,
    OP_SOFTRST = 2'd2,
    OP_NONE    = 2'd3
  } fifo_op_e;

  localparam logic [7:0] INTR_FUNC_DONE = 8'h08;
endpackage

// File: rtl/sfifo_xfer.sv
module sfifo_xfer #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 17,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_resp,
  input  logic [7:0]       resp_byte,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  input  logic             rd_block,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] phase_cnt,
  output logic [PW:0]      occupancy,
  output logic             ovr
);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

  logic [7:0]       mem_q [DEPTH];
  logic [DEPTH-1:0] mem_we;
  logic [7:0]       mem_wd [DEPTH];
  logic [PW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       rdat_q, rdat_d;
  logic             ovr_q, ovr_d;
  logic             wr_ok;

  assign wr_ok = wr_en && !clr && !load_resp && !flush && (wptr_q != LAST_SLOT);

  // per-entry write enables: response load writes slots 0/1, push writes wptr
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < 2) begin : g_resp
      assign mem_we[i] = (!clr && load_resp) || (wr_ok && wptr_q == PW'(i));
      assign mem_wd[i] = (!clr && load_resp) ? ((i == 0) ? resp_byte : 8'h00) : wr_data;
    end else begin : g_data
      assign mem_we[i] = wr_ok && wptr_q == PW'(i);
      assign mem_wd[i] = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (mem_we[i]) mem_q[i] <= mem_wd[i];
    end
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    rdat_d = rdat_q;
    ovr_d  = 1'b0;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
      rdat_d = '0;
    end else if (load_resp) begin
      rptr_d = '0;
      wptr_d = PW'(2);
      cnt_d  = CNT_W'(2);
    end else if (flush) begin
      rptr_d = '0;
      wptr_d = '0;
    end else if (wr_en) begin
      if (wptr_q == LAST_SLOT) begin
        ovr_d = 1'b1;
      end else begin
        wptr_d = wptr_q + PW'(1);
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end else if (rd_en) begin
      if (rd_block) begin
        rdat_d = 8'h00;
      end else if (rptr_q < wptr_q) begin
        rdat_d = mem_q[rptr_q];
        rptr_d = rptr_q + PW'(1);
        cnt_d  = cnt_q - CNT_W'(1);
      end
      if (rptr_d == wptr_d) begin
        rptr_d = '0;
        wptr_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      rdat_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      rdat_q <= rdat_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rd_data   = rdat_q;
  assign phase_cnt = cnt_q;
  assign occupancy = {1'b0, wptr_q} - {1'b0, rptr_q};
  assign ovr       = ovr_q;

  assert_ptr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_q <= wptr_q);
  assert_drain_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr_q == wptr_q) |-> (wptr_q == '0));
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && !load_resp && !flush && wptr_q == LAST_SLOT)
      |=> ($stable(wptr_q) && $stable(cnt_q) && ovr));
  assert_block_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_block && !wr_en && !clr && !load_resp && !flush)
      |=> (rd_data == 8'h00 && $stable(rptr_q) && $stable(cnt_q)));
endmodule

// File: rtl/sfifo_cmdbuf.sv
module sfifo_cmdbuf #(
  parameter int CMD_DEPTH = 16,
  parameter int CIW       = $clog2(CMD_DEPTH),
  parameter int CLW       = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           restart,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  input  logic [CIW-1:0] rd_idx,
  output logic [7:0]     rd_data,
  output logic [CLW-1:0] len,
  output logic           ovr
);
  localparam logic [CLW-1:0] CAP = CLW'(CMD_DEPTH);

  logic [7:0]           mem_q [CMD_DEPTH];
  logic [CMD_DEPTH-1:0] mem_we;
  logic [CLW-1:0]       len_q, len_d;
  logic                 ovr_q, ovr_d;
  logic                 take;

  assign take = wr_en && !clr && !restart && (len_q != CAP);

  for (genvar i = 0; i < CMD_DEPTH; i++) begin : g_cslot
    assign mem_we[i] = take && (len_q == CLW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < CMD_DEPTH; i++) begin
      if (mem_we[i]) mem_q[i] <= wr_data;
    end
  end

  always_comb begin
    len_d = len_q;
    ovr_d = 1'b0;
    if (clr || restart) begin
      len_d = '0;
    end else if (wr_en) begin
      if (len_q == CAP) ovr_d = 1'b1;
      else              len_d = len_q + CLW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      len_q <= len_d;
      ovr_q <= ovr_d;
    end
  end

  assign rd_data = mem_q[rd_idx];
  assign len     = len_q;
  assign ovr     = ovr_q;

  assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= CAP);
  assert_cmd_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && !restart && len_q == CAP) |=> ($stable(len_q) && ovr));
endmodule

// File: rtl/sfifo_event.sv
module sfifo_event
  import sfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       resp,
  input  logic       flush,
  input  logic       ack,
  output logic       irq,
  output logic [7:0] intr_code
);
  logic       irq_q, irq_d;
  logic [7:0] code_q, code_d;

  always_comb begin
    irq_d  = irq_q;
    code_d = code_q;
    if (clr) begin
      irq_d  = 1'b0;
      code_d = '0;
    end else if (resp) begin
      irq_d  = 1'b1;
      code_d = INTR_FUNC_DONE;
    end else if (flush) begin
      code_d = INTR_FUNC_DONE;
    end else if (ack) begin
      irq_d  = 1'b0;
      code_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      code_q <= '0;
    end else begin
      irq_q  <= irq_d;
      code_q <= code_d;
    end
  end

  assign irq       = irq_q;
  assign intr_code = code_q;

  assert_resp_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp && !clr) |=> (irq && intr_code == INTR_FUNC_DONE));
  assert_ack_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !resp && !flush && !clr) |=> (!irq && intr_code == 8'h00));
  assert_flush_keep_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !resp && !clr) |=> ($stable(irq) && intr_code == INTR_FUNC_DONE));
endmodule

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo
  import sfifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int CNT_W     = 17,
  parameter int CIW       = $clog2(CMD_DEPTH),
  parameter int CLW       = $clog2(CMD_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  input  logic [2:0]       phase_in,
  output logic [7:0]       rd_data,
  input  logic             collect_start,
  input  logic             collect_end,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       status_byte,
  input  logic             irq_ack,
  input  logic [CIW-1:0]   cmd_rd_idx,
  output logic [7:0]       cmd_rd_data,
  output logic [CLW-1:0]   cmd_len,
  output logic [CNT_W-1:0] phase_count,
  output logic [7:0]       flags,
  output logic             overrun,
  output logic             irq,
  output logic [7:0]       intr_code
);
  localparam int PW = $clog2(DEPTH);

  logic          do_soft, do_resp, do_flush;
  logic          wr_go, rd_go;
  logic          collect_q, collect_d;
  logic [PW:0]   occ;
  logic          ovr_x, ovr_c;

  assign do_soft  = cmd_valid && (fifo_op_e'(cmd_op) == OP_SOFTRST);
  assign do_resp  = cmd_valid && (fifo_op_e'(cmd_op) == OP_STATUS);
  assign do_flush = cmd_valid && (fifo_op_e'(cmd_op) == OP_FLUSH);
  assign wr_go    = wr_en && !cmd_valid;
  assign rd_go    = rd_en && !cmd_valid && !wr_en;

  always_comb begin
    collect_d = collect_q;
    if (do_soft)            collect_d = 1'b0;
    else if (collect_start) collect_d = 1'b1;
    else if (collect_end)   collect_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) collect_q <= 1'b0;
    else        collect_q <= collect_d;
  end

  sfifo_xfer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (do_soft),
    .load_resp (do_resp),
    .resp_byte (status_byte),
    .flush     (do_flush),
    .wr_en     (wr_go && !collect_q),
    .wr_data   (wr_data),
    .rd_en     (rd_go),
    .rd_block  (phase_in == 3'b000),
    .rd_data   (rd_data),
    .phase_cnt (phase_count),
    .occupancy (occ),
    .ovr       (ovr_x)
  );

  sfifo_cmdbuf #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (do_soft),
    .restart (collect_start),
    .wr_en   (wr_go && collect_q),
    .wr_data (wr_data),
    .rd_idx  (cmd_rd_idx),
    .rd_data (cmd_rd_data),
    .len     (cmd_len),
    .ovr     (ovr_c)
  );

  sfifo_event u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (do_soft),
    .resp      (do_resp),
    .flush     (do_flush),
    .ack       (irq_ack),
    .irq       (irq),
    .intr_code (intr_code)
  );

  assign flags   = 8'(occ);
  assign overrun = ovr_x | ovr_c;

  assert_collect_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && collect_q) |=> ($stable(phase_count) && $stable(flags)));
  assert_flags_high_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    flags[7:5] == 3'b000);
  assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    do_soft |=> (phase_count == '0 && flags == 8'h00 && !irq && cmd_len == '0));
  assert_ovr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovr_x && ovr_c));
endmodule

// File: tb/tb_scsi_byte_fifo.sv
module tb_scsi_byte_fifo;
  localparam int DEPTH = 16;
  localparam int CMDD  = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, collect_start, collect_end, cmd_valid, irq_ack;
  logic [7:0]  wr_data, status_byte;
  logic [2:0]  phase_in;
  logic [1:0]  cmd_op;
  logic [3:0]  cmd_rd_idx;
  logic [7:0]  rd_data, cmd_rd_data, flags, intr_code;
  logic [4:0]  cmd_len;
  logic [16:0] phase_count;
  logic        overrun, irq;

  always #10 clk = ~clk;

  scsi_byte_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .phase_in(phase_in), .rd_data(rd_data), .collect_start(collect_start),
    .collect_end(collect_end), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .status_byte(status_byte), .irq_ack(irq_ack), .cmd_rd_idx(cmd_rd_idx),
    .cmd_rd_data(cmd_rd_data), .cmd_len(cmd_len), .phase_count(phase_count),
    .flags(flags), .overrun(overrun), .irq(irq), .intr_code(intr_code)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_buf [DEPTH];
  logic [7:0] m_cmd [CMDD];
  int m_w, m_r, m_cnt, m_clen, m_intr;
  logic [7:0] m_rd;
  bit m_col, m_irq, m_ovr;

  function automatic int occ_of(int w, int r);
    return w - r;
  endfunction

  function automatic bit push_refused(int w);
    return w == DEPTH - 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_w = 0; m_r = 0; m_cnt = 0; m_clen = 0; m_intr = 0;
    m_rd = 8'h00; m_col = 0; m_irq = 0; m_ovr = 0;
  endtask

  task automatic model_step(input bit w, input logic [7:0] d, input bit r,
                            input logic [2:0] ph, input bit cs, input bit ce,
                            input bit cv, input logic [1:0] op,
                            input logic [7:0] sb, input bit ack);
    m_ovr = 0;
    if (cv && op == 2'd2) begin
      model_reset();
      return;
    end
    if (cv && op == 2'd1) begin
      m_buf[0] = sb; m_buf[1] = 8'h00; m_r = 0; m_w = 2; m_cnt = 2;
      m_irq = 1; m_intr = 8;
    end else if (cv && op == 2'd0) begin
      m_r = 0; m_w = 0; m_intr = 8;
    end else begin
      if (ack) begin m_irq = 0; m_intr = 0; end
      if (!cv && w) begin
        if (m_col) begin
          if (m_clen < CMDD) begin m_cmd[m_clen] = d; m_clen++; end
          else m_ovr = 1;
        end else if (push_refused(m_w)) m_ovr = 1;
        else begin m_buf[m_w] = d; m_w++; m_cnt++; end
      end else if (!cv && r) begin
        if (ph == 3'b000) m_rd = 8'h00;
        else if (m_r < m_w) begin m_rd = m_buf[m_r]; m_r++; m_cnt--; end
        if (m_r == m_w) begin m_r = 0; m_w = 0; end
      end
    end
    if (cs) begin m_col = 1; m_clen = 0; end
    else if (ce) m_col = 0;
  endtask

  task automatic compare(input string tag);
    chk(rd_data == m_rd, {tag, " rd_data"}, rd_data, m_rd);
    chk($signed(phase_count) == m_cnt, {tag, " phase_count"}, $signed(phase_count), m_cnt);
    chk(flags == 8'(occ_of(m_w, m_r)), {tag, " flags"}, flags, occ_of(m_w, m_r));
    chk(overrun == m_ovr, {tag, " overrun"}, overrun, m_ovr);
    chk(irq == m_irq, {tag, " irq"}, irq, m_irq);
    chk(intr_code == 8'(m_intr), {tag, " intr_code"}, intr_code, m_intr);
    chk(cmd_len == 5'(m_clen), {tag, " cmd_len"}, cmd_len, m_clen);
  endtask

  task automatic cyc(input string tag, input bit w, input logic [7:0] d, input bit r,
                     input logic [2:0] ph, input bit cs, input bit ce, input bit cv,
                     input logic [1:0] op, input logic [7:0] sb, input bit ack);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; phase_in = ph; collect_start = cs;
    collect_end = ce; cmd_valid = cv; cmd_op = op; status_byte = sb; irq_ack = ack;
    @(posedge clk);
    model_step(w, d, r, ph, cs, ce, cv, op, sb, ack);
    @(negedge clk);
    wr_en = 0; rd_en = 0; collect_start = 0; collect_end = 0; cmd_valid = 0; irq_ack = 0;
    compare(tag);
  endtask

  task automatic wr(input string tag, input logic [7:0] d);
    cyc(tag, 1, d, 0, 3'd1, 0, 0, 0, 2'd3, 8'h00, 0);
  endtask
  task automatic rd(input string tag, input logic [2:0] ph);
    cyc(tag, 0, 8'h00, 1, ph, 0, 0, 0, 2'd3, 8'h00, 0);
  endtask
  task automatic op(input string tag, input logic [1:0] o, input logic [7:0] sb);
    cyc(tag, 0, 8'h00, 0, 3'd1, 0, 0, 1, o, sb, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; wr_en = 0; rd_en = 0; wr_data = 0; phase_in = 3'd1;
    collect_start = 0; collect_end = 0; cmd_valid = 0; cmd_op = 2'd3;
    status_byte = 0; irq_ack = 0; cmd_rd_idx = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");

    // R4 push, R6 pop order, R13 occupancy
    wr("R4 push", 8'hA1); wr("R4 push", 8'hB2); wr("R13 occupancy", 8'hC3);
    rd("R6 pop", 3'd1); rd("R6 pop", 3'd1); rd("R6 pop drain", 3'd1);
    // R7 empty read keeps rd_data
    rd("R7 empty read", 3'd1);
    // R5 data-out read
    wr("R5 setup", 8'h5A);
    rd("R5 blocked read", 3'b000);
    rd("R6 pop after block", 3'd2);
    // R4 refusal at DEPTH-1, R8 drain then refill
    for (int i = 0; i < DEPTH - 1; i++) wr("R4 fill", 8'(i + 16));
    wr("R4 refused", 8'hEE);
    for (int i = 0; i < DEPTH - 1; i++) rd("R8 drain", 3'd3);
    for (int i = 0; i < DEPTH - 1; i++) wr("R8 refill", 8'(i + 64));
    chk(overrun == 1'b0, "R8 no early overrun", overrun, 0);
    // R10 flush keeps count and irq
    op("R10 flush", 2'd0, 8'h00);
    // R9 status response then pops
    op("R9 status load", 2'd1, 8'h3C);
    rd("R9 status byte", 3'd3);
    rd("R9 message byte", 3'd3);
    // R12 ack
    cyc("R12 ack", 0, 8'h00, 0, 3'd1, 0, 0, 0, 2'd3, 8'h00, 1);
    // R2 collection, R3 overflow
    cyc("R2 start", 0, 8'h00, 0, 3'd1, 1, 0, 0, 2'd3, 8'h00, 0);
    for (int i = 0; i < CMDD; i++) wr("R2 collect", 8'(8'hC0 + i));
    wr("R3 cmd overflow", 8'hFF);
    cyc("R2 end", 0, 8'h00, 0, 3'd1, 0, 1, 0, 2'd3, 8'h00, 0);
    for (int i = 0; i < CMDD; i++) begin
      cmd_rd_idx = 4'(i);
      #1;
      chk(cmd_rd_data == 8'(8'hC0 + i), "R2 cmd contents", cmd_rd_data, 8'hC0 + i);
    end
    wr("R4 after collect", 8'h11);
    // R11 soft reset
    cyc("R11 setup", 0, 8'h00, 0, 3'd1, 1, 0, 0, 2'd3, 8'h00, 0);
    wr("R11 setup", 8'h22);
    op("R9 irq setup", 2'd1, 8'h44);
    op("R11 soft reset", 2'd2, 8'h00);
    wr("R11 mode cleared", 8'h33);

    // random mix: R4 R6 R5 R7 R10 R9 R12
    for (int n = 0; n < 4000; n++) begin
      int k;
      bit w, r, cs, ce, cv, ack;
      logic [1:0] o;
      k = $urandom_range(0, 99);
      w = (k < 40); r = (k >= 40 && k < 80);
      cv = (k >= 80 && k < 86);
      o = (k < 83) ? 2'd0 : ((k < 85) ? 2'd1 : 2'd2);
      cs = (k >= 86 && k < 88); ce = (k >= 88 && k < 92);
      ack = ($urandom_range(0, 9) == 0);
      cyc("R4 R6 R9 R10 R12 random", w, 8'($urandom), r, 3'($urandom_range(0, 3)),
          cs, ce, cv, o, 8'($urandom), ack);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule